// File: doc/BRIEF.md
# Circular Sampling Ring Controller

This block holds the digital control for a switched-capacitor waveform sampler. A write pointer moves through a ring of storage cells at one cell per clock and wraps without end, so that the ring always holds the most recent stretch of the waveform. When a trigger is accepted, the pointer keeps running for a programmable number of further cycles. It then freezes, and the cell where it stopped is recorded. Because of this delay, the frozen ring contains signal from before the trigger as well as from after it.

Once the pointer is frozen, a region-of-interest readout walks a programmable number of cells. It starts at the stop cell, wraps modulo the ring depth, and emits one cell index per readout step. A step lasts a fixed number of clock cycles, which models a slower digitizer clock. The storage can be partitioned into short rings, or neighbouring channels can be cascaded into one longer ring. Sampling stays halted until the window has been read out. Triggers that arrive while the block is busy are dropped and tallied. The analog cells and the digitizer are not part of this block, which only produces cell indices.

Top module: `sring_ctrl`

## Requirements
- R1: While sampling, `wr_cell_o` advances by one per clock and goes from depth-1 to 0. The ring depth is BASE_DEPTH shifted left by the cascade code, with codes 0,1,2,3 giving 1x, 2x, 4x and 8x BASE_DEPTH.
- R2: A trigger sampled high while idle is accepted. With delay D and pointer value P at that edge, the pointer advances D+1 more times counting that edge, then freezes, and `stop_cell_o` becomes (P+D+1) mod depth.
- R3: During readout, `sampling_o` is low and `wr_cell_o` holds the stop cell.
- R4: The readout emits W strobes on `rd_valid_o`, where W is the window clamped to the range 1..depth (window 0 gives one strobe). Strobe k carries (stop+k) mod depth on `rd_cell_o`. The first strobe appears in the first cycle of readout.
- R5: Consecutive readout strobes are RD_DIV clock cycles apart.
- R6: `busy_o` falls RD_DIV cycles after the last strobe. On the next clock the pointer resumes from stop+1.
- R7: Every cycle in which `trig_i` is high while busy is ignored for capture and increments `drop_cnt_o`. The count saturates at 2^CNT_W-1.
- R8: Cascade code, window and delay are taken only while idle with no trigger present. A change made while busy has no effect on the capture in progress. A depth change that leaves the pointer beyond the new ring makes the pointer wrap to 0.
- R9: After reset the pointer and stop cell are 0, the block is idle and sampling, no strobe is issued, and the drop count is 0.
- R10: `busy_o` is high and `ready_o` low from the clock edge that accepts a trigger until the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Trigger request, sampled each clock |
| cfg_cascade_i | input | MODE_W | Cascade code; ring depth is BASE_DEPTH << code |
| cfg_window_i | input | CELL_W+1 | Number of cells to read out |
| cfg_delay_i | input | DLY_W | Clocks between trigger and freeze |
| wr_cell_o | output | CELL_W | Current write pointer |
| sampling_o | output | 1 | Pointer is moving |
| busy_o | output | 1 | Capture in progress (delay or readout) |
| ready_o | output | 1 | Idle and able to accept a trigger |
| stop_cell_o | output | CELL_W | Cell where the pointer froze |
| rd_valid_o | output | 1 | Readout index strobe |
| rd_cell_o | output | CELL_W | Readout cell index |
| drop_cnt_o | output | CNT_W | Saturating count of ignored trigger cycles |

## Verification
Captures are run in all four cascade depths. The delays chosen put the stop cell both mid-ring and next to the wrap point, which separates modulo errors in the freeze arithmetic from errors in the readout walk. The windows used are a short window, a window of 0, a window equal to the depth, and a window larger than the depth, so that an off-by-one in the count or a failed clamp shows up as a missing or extra strobe. Trigger bursts held during delay and readout exercise both the drop tally and its saturation. A window change made while busy, and a depth change made while the pointer lies outside the new ring, show whether the configuration is taken at the right moment.

// File: rtl/sring_pkg.sv
// Package: shared types for the circular sampling ring controller.
// Assumes: used by all sring_* modules; holds no logic.
package sring_pkg;

    // Phase of a capture: free-running, waiting out the delay, reading out.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_READ  = 2'd2
    } ring_phase_t;

endpackage

// File: rtl/sring_cfg.sv
// Module: configuration latch. Takes the cascade code, window and delay
// and turns them into a ring depth, a clamped window and a delay value.
// Assumes: load_i is high only when the sequencer is idle with no trigger,
// so the latched values stay constant for the whole of a capture.
module sring_cfg #(
    parameter int BASE_DEPTH = 1024,
    parameter int NUM_MODES  = 4,
    parameter int MODE_W     = 2,
    parameter int WIN_W      = 14,
    parameter int DLY_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MODE_W-1:0] cascade_i,
    input  logic [WIN_W-1:0]  window_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic [WIN_W-1:0]  depth_o,
    output logic [WIN_W-1:0]  win_o,
    output logic [DLY_W-1:0]  delay_o
);

    logic [WIN_W-1:0]  depth_tbl [NUM_MODES];
    logic [MODE_W-1:0] mode_sel;
    logic [WIN_W-1:0]  depth_nxt;
    logic [WIN_W-1:0]  win_nxt;

    // One depth entry per cascade code: base depth doubled per step.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_depth
        assign depth_tbl[m] = WIN_W'(BASE_DEPTH << m);
    end

    // Clamp an out-of-range cascade code to the deepest ring.
    always_comb begin
        if (32'(cascade_i) >= NUM_MODES) mode_sel = MODE_W'(NUM_MODES - 1);
        else                             mode_sel = cascade_i;
        depth_nxt = depth_tbl[mode_sel];
    end

    // Clamp the window into 1..depth.
    always_comb begin
        if (window_i == '0)              win_nxt = WIN_W'(1);
        else if (window_i > depth_nxt)   win_nxt = depth_nxt;
        else                             win_nxt = window_i;
    end

    // Latch the configuration while idle; hold it while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_o <= WIN_W'(BASE_DEPTH);
            win_o   <= WIN_W'(1);
            delay_o <= '0;
        end else if (load_i) begin
            depth_o <= depth_nxt;
            win_o   <= win_nxt;
            delay_o <= delay_i;
        end
    end

endmodule

// File: rtl/sring_seq.sv
// Module: capture sequencer. Accepts a trigger while idle, counts down the
// latency, freezes the pointer and waits for the readout to finish.
// Assumes: rd_done_i is a single-cycle indication raised only in PH_READ.
module sring_seq
    import sring_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             rd_done_i,
    output ring_phase_t      phase_o,
    output logic             advance_o,
    output logic             freeze_o,
    output logic             drop_o,
    output logic             cfg_load_o
);

    ring_phase_t      phase_q;
    logic [DLY_W-1:0] dly_q;

    // Phase and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            dly_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (trig_i) begin
                        phase_q <= PH_DELAY;
                        dly_q   <= delay_i;
                    end
                end
                PH_DELAY: begin
                    if (dly_q == '0) phase_q <= PH_READ;
                    else             dly_q   <= dly_q - 1'b1;
                end
                PH_READ: begin
                    if (rd_done_i) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Control strobes derived from the phase.
    always_comb begin
        advance_o  = (phase_q == PH_IDLE) || (phase_q == PH_DELAY && dly_q != '0);
        freeze_o   = (phase_q == PH_DELAY) && (dly_q == '0);
        drop_o     = trig_i && (phase_q != PH_IDLE);
        cfg_load_o = (phase_q == PH_IDLE) && !trig_i;
    end

    assign phase_o = phase_q;

    // R2: the freeze is reached only after passing through the delay phase.
    assert_freeze_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_READ && $past(phase_q) != PH_READ) |-> $past(phase_q) == PH_DELAY);

endmodule

// File: rtl/sring_wptr.sv
// Module: write pointer. Sweeps the ring, wraps at depth-1, and records
// the stop cell when asked to freeze.
// Assumes: advance_i and capture_i are never high together.
module sring_wptr #(
    parameter int CELL_W = 13,
    parameter int WIN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic              capture_i,
    input  logic [WIN_W-1:0]  depth_i,
    output logic [CELL_W-1:0] ptr_o,
    output logic [CELL_W-1:0] stop_o
);

    logic at_end;

    // A pointer on or beyond the last cell of the ring wraps to cell 0.
    assign at_end = ({1'b0, ptr_o} >= depth_i - 1'b1);

    // Pointer advance and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_o <= '0;
        else if (advance_i)  ptr_o <= at_end ? '0 : ptr_o + 1'b1;
    end

    // Record the frozen cell.
    always_ff @(posedge clk) begin
        if (!rst_n)          stop_o <= '0;
        else if (capture_i)  stop_o <= ptr_o;
    end

    // R1: inside the ring the pointer steps by exactly one.
    assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !at_end) |=> ptr_o == $past(ptr_o) + 1'b1);

    // R3: without an advance the pointer holds.
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(ptr_o));

endmodule

// File: rtl/sring_roi.sv
// Module: region-of-interest reader. Starting at the stop cell, emits a
// window of cell indices, one per RD_DIV clocks, wrapping at the ring depth.
// Assumes: start_i is a single-cycle pulse, and depth_i and win_i stay
// constant until done_o.
module sring_roi #(
    parameter int CELL_W = 13,
    parameter int WIN_W  = 14,
    parameter int RD_DIV = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CELL_W-1:0] start_cell_i,
    input  logic [WIN_W-1:0]  depth_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic              rd_valid_o,
    output logic [CELL_W-1:0] rd_cell_o,
    output logic              done_o
);

    localparam int DIV_W = (RD_DIV > 1) ? $clog2(RD_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_RELOAD = DIV_W'(RD_DIV - 1);

    logic              active_q;
    logic [WIN_W-1:0]  k_q;
    logic [DIV_W-1:0]  div_q;
    logic [CELL_W-1:0] next_cell;

    // Next index around the ring.
    assign next_cell = ({1'b0, rd_cell_o} >= depth_i - 1'b1) ? '0 : rd_cell_o + 1'b1;

    // Window complete once the last step's pacing has run out.
    assign done_o = active_q && (div_q == '0) && (k_q == win_i);

    // Readout walk: pacing counter, emitted count and current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            k_q        <= '0;
            div_q      <= '0;
            rd_valid_o <= 1'b0;
            rd_cell_o  <= '0;
        end else begin
            rd_valid_o <= 1'b0;
            if (start_i) begin
                active_q   <= 1'b1;
                rd_valid_o <= 1'b1;
                rd_cell_o  <= start_cell_i;
                k_q        <= WIN_W'(1);
                div_q      <= DIV_RELOAD;
            end else if (active_q) begin
                if (div_q != '0) begin
                    div_q <= div_q - 1'b1;
                end else if (k_q == win_i) begin
                    active_q <= 1'b0;
                end else begin
                    rd_valid_o <= 1'b1;
                    rd_cell_o  <= next_cell;
                    k_q        <= k_q + 1'b1;
                    div_q      <= DIV_RELOAD;
                end
            end
        end
    end

    // R4: every emitted index lies inside the ring.
    assert_cell_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ({1'b0, rd_cell_o} < depth_i));

    // R5: with pacing above one clock, strobes never come back to back.
    assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && RD_DIV > 1) |=> !rd_valid_o);

endmodule

// File: rtl/sring_dropcnt.sv
// Module: saturating tally of trigger cycles ignored while busy.
// Assumes: inc_i is high for at most one count per clock.
module sring_dropcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up and stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end

    // R7: a full counter stays full.
    assert_drop_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

    // R7: without an ignored trigger the tally does not move.
    assert_drop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/sring_ctrl.sv
// Module: circular sampling ring controller (top). Ties together the
// configuration latch, capture sequencer, write pointer, readout walker and
// drop tally.
// Assumes: a single clock; the readout rate is modelled by RD_DIV clocks per
// index; the cell contents are outside this block.
module sring_ctrl
    import sring_pkg::*;
#(
    parameter int BASE_DEPTH = 1024,
    parameter int NUM_MODES  = 4,
    parameter int DLY_W      = 16,
    parameter int CNT_W      = 8,
    parameter int RD_DIV     = 6,
    localparam int MAX_DEPTH = BASE_DEPTH << (NUM_MODES - 1),
    localparam int CELL_W    = $clog2(MAX_DEPTH),
    localparam int WIN_W     = CELL_W + 1,
    localparam int MODE_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [MODE_W-1:0] cfg_cascade_i,
    input  logic [WIN_W-1:0]  cfg_window_i,
    input  logic [DLY_W-1:0]  cfg_delay_i,
    output logic [CELL_W-1:0] wr_cell_o,
    output logic              sampling_o,
    output logic              busy_o,
    output logic              ready_o,
    output logic [CELL_W-1:0] stop_cell_o,
    output logic              rd_valid_o,
    output logic [CELL_W-1:0] rd_cell_o,
    output logic [CNT_W-1:0]  drop_cnt_o
);

    ring_phase_t      phase;
    logic             advance, freeze, drop, cfg_load, rd_done;
    logic [WIN_W-1:0] depth, win;
    logic [DLY_W-1:0] delay;

    sring_cfg #(
        .BASE_DEPTH(BASE_DEPTH), .NUM_MODES(NUM_MODES), .MODE_W(MODE_W),
        .WIN_W(WIN_W), .DLY_W(DLY_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load),
        .cascade_i(cfg_cascade_i), .window_i(cfg_window_i), .delay_i(cfg_delay_i),
        .depth_o(depth), .win_o(win), .delay_o(delay)
    );

    sring_seq #(.DLY_W(DLY_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .delay_i(delay),
        .rd_done_i(rd_done), .phase_o(phase), .advance_o(advance),
        .freeze_o(freeze), .drop_o(drop), .cfg_load_o(cfg_load)
    );

    sring_wptr #(.CELL_W(CELL_W), .WIN_W(WIN_W)) wptr_i (
        .clk(clk), .rst_n(rst_n), .advance_i(advance), .capture_i(freeze),
        .depth_i(depth), .ptr_o(wr_cell_o), .stop_o(stop_cell_o)
    );

    sring_roi #(.CELL_W(CELL_W), .WIN_W(WIN_W), .RD_DIV(RD_DIV)) roi_i (
        .clk(clk), .rst_n(rst_n), .start_i(freeze), .start_cell_i(wr_cell_o),
        .depth_i(depth), .win_i(win), .rd_valid_o(rd_valid_o),
        .rd_cell_o(rd_cell_o), .done_o(rd_done)
    );

    sring_dropcnt #(.CNT_W(CNT_W)) drop_i (
        .clk(clk), .rst_n(rst_n), .inc_i(drop), .cnt_o(drop_cnt_o)
    );

    // Status flags seen by the surrounding logic.
    always_comb begin
        sampling_o = (phase != PH_READ);
        busy_o     = (phase != PH_IDLE);
        ready_o    = (phase == PH_IDLE);
    end

    // R3: no readout strobe while the pointer is moving.
    assert_no_strobe_sampling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !sampling_o);

    // R2: the recorded stop cell equals the frozen pointer.
    assert_stop_matches_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (stop_cell_o == wr_cell_o));

    // R10: an accepted trigger makes the block busy on the next cycle.
    assert_busy_after_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && trig_i) |=> (busy_o && !ready_o));

endmodule

// File: tb/sring_ctrl_tb_top.sv
`timescale 1ns/1ps
module sring_ctrl_tb_top;

    localparam int BASE   = 16;
    localparam int NM     = 4;
    localparam int DW     = 8;
    localparam int CW     = 3;
    localparam int DIV    = 2;
    localparam int CELL_W = 7;
    localparam int WIN_W  = 8;
    localparam int CMAX   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig = 1'b0;
    logic [1:0]        cascade = '0;
    logic [WIN_W-1:0]  window = '0;
    logic [DW-1:0]     delay = '0;
    logic [CELL_W-1:0] wr_cell, stop_cell, rd_cell;
    logic              sampling, busy, ready, rd_valid;
    logic [CW-1:0]     drop_cnt;

    always #2.5 clk = ~clk;

    sring_ctrl #(
        .BASE_DEPTH(BASE), .NUM_MODES(NM), .DLY_W(DW), .CNT_W(CW), .RD_DIV(DIV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .cfg_cascade_i(cascade),
        .cfg_window_i(window), .cfg_delay_i(delay), .wr_cell_o(wr_cell),
        .sampling_o(sampling), .busy_o(busy), .ready_o(ready),
        .stop_cell_o(stop_cell), .rd_valid_o(rd_valid), .rd_cell_o(rd_cell),
        .drop_cnt_o(drop_cnt)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int last_strobe = -1;
    int exp_q[$];
    int e_val;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected readout indices and checks pacing and freeze.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected strobe", int'(rd_cell), -1);
                end else begin
                    e_val = exp_q.pop_front();
                    check(int'(rd_cell) == e_val, "R4 readout index", int'(rd_cell), e_val);
                end
                if (last_strobe >= 0)
                    check(cyc - last_strobe == DIV, "R5 strobe spacing", cyc - last_strobe, DIV);
                last_strobe = cyc;
            end
            if (busy && !sampling)
                check(wr_cell == stop_cell, "R3 pointer frozen", int'(wr_cell), int'(stop_cell));
        end
    end

    // Driver: one capture, with optional trigger burst and window change while busy.
    task automatic capture(input int mode, input int win, input int dly,
                           input int extra, input int late_win);
        int depth, wn, p, stop, d0, exp_drop;
        depth = BASE << mode;
        wn = (win == 0) ? 1 : ((win > depth) ? depth : win);
        @(negedge clk);
        cascade = 2'(mode);
        window  = WIN_W'(win);
        delay   = DW'(dly);
        repeat (3) @(negedge clk);
        p  = int'(wr_cell);
        d0 = int'(drop_cnt);
        stop = (p + dly + 1) % depth;
        for (int k = 0; k < wn; k++) exp_q.push_back((stop + k) % depth);
        last_strobe = -1;
        trig = 1'b1;
        @(negedge clk);
        trig = (extra > 0);
        check(busy && !ready, "R10 busy after trigger", int'(busy), 1);
        if (late_win >= 0) window = WIN_W'(late_win);
        for (int i = 1; i < extra; i++) @(negedge clk);
        if (extra > 0) begin
            @(negedge clk);
            trig = 1'b0;
        end
        while (busy) @(negedge clk);
        check(cyc - last_strobe == DIV, "R6 idle after last strobe", cyc - last_strobe, DIV);
        check(exp_q.size() == 0, "R4 strobe count", wn - exp_q.size(), wn);
        exp_q.delete();
        check(int'(stop_cell) == stop, "R2 stop cell", int'(stop_cell), stop);
        check(int'(wr_cell) == stop, "R6 pointer at stop on return", int'(wr_cell), stop);
        exp_drop = (d0 + extra > CMAX) ? CMAX : d0 + extra;
        check(int'(drop_cnt) == exp_drop, "R7 drop count", int'(drop_cnt), exp_drop);
        @(negedge clk);
        check(int'(wr_cell) == (stop + 1) % depth, "R6 sampling resumes",
              int'(wr_cell), (stop + 1) % depth);
    endtask

    task automatic run_steps(input int n, input int depth, input string req);
        int prev;
        prev = int'(wr_cell);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(int'(wr_cell) == (prev + 1) % depth, req, int'(wr_cell), (prev + 1) % depth);
            prev = int'(wr_cell);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check(wr_cell == '0 && stop_cell == '0, "R9 reset pointers", int'(wr_cell), 0);
        check(ready && !busy && sampling, "R9 reset idle", int'(busy), 0);
        check(!rd_valid && drop_cnt == '0, "R9 reset strobe/drops", int'(drop_cnt), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        // R1 free-running wrap in the shortest ring
        run_steps(40, BASE, "R1 pointer step/wrap depth 16");
        capture(0, 5, 3, 0, -1);
        capture(0, 10, 0, 0, -1);
        capture(1, 32, 7, 0, -1);
        capture(3, 0, 20, 0, -1);
        capture(2, 200, 1, 0, -1);
        // R8 window change while busy, plus R7 ignored triggers
        capture(0, 6, 5, 4, 12);
        // R7 saturation
        capture(0, 4, 10, 6, -1);
        // R8 depth change while idle with pointer beyond new ring
        @(negedge clk);
        cascade = 2'd3;
        while (int'(wr_cell) < 40) @(negedge clk);
        cascade = 2'd0;
        repeat (3) @(negedge clk);
        check(int'(wr_cell) < BASE, "R8 pointer inside new ring", int'(wr_cell), BASE - 1);
        run_steps(20, BASE, "R8 stepping after depth change");
        // R1 longest ring, step check
        cascade = 2'd3;
        repeat (2) @(negedge clk);
        run_steps(150, BASE << 3, "R1 pointer step/wrap depth 128");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule